// File: doc/BRIEF.md
# Dual-Resolution SAR ADC Sequencer

This block is the digital controller of an eight-input successive-approximation analog-to-digital converter. A start pulse launches one conversion on the channel and at the resolution presented with it. The block steers the analog input multiplexer, drives a trial code into an external DAC, reads back one comparator bit per machine cycle and builds a straight-binary result. The multiplexer, DAC and comparator sit outside the block.

Time is counted in machine cycles of twelve system clocks. A full-resolution conversion takes fifty machine cycles and yields ten bits. A faster mode takes twenty-four machine cycles and yields eight bits, which are placed in the upper eight bits of the result. The cycles that are not bit trials come first and are spent on input sampling and settling. When the chip is idle, a keep-alive input decides whether the converter keeps running or is powered down. A power-down aborts any conversion that is in progress.

Top module: `sar_adc_seq`

## Requirements
- R1: The channel given with an accepted start is latched, driven on `mux_sel_o`, and held constant for the whole conversion.
- R2: In 10-bit mode (`mode8_i`=0) the final `result_o` is the largest 10-bit code whose DAC level is at or below the input. A trial bit is kept when `cmp_i` is 1, meaning the input is at or above the trial code.
- R3: A 10-bit conversion ends with `done_o` rising exactly 600 clocks (50 machine cycles of 12 clocks) after the clock edge that accepts the start.
- R4: In 8-bit mode (`mode8_i`=1) `done_o` rises 288 clocks (24 machine cycles) after the accepting edge. The 8-bit result is in `result_o[9:2]`, and `result_o[1:0]` is 0.
- R5: `dac_code_o` is 0 during the sampling phase. Bits are then tried most-significant first, one per machine cycle, each trial code being the kept bits plus the bit under test. In 10-bit mode `dac_code_o` first shows 0x200, 480 clocks after the accepting edge.
- R6: `done_o` rises only when a conversion completes and falls at the next accepted start. `done_o` and `busy_o` are never high together.
- R7: A start while `busy_o` is high is ignored. The channel, the mode, the end time and the result of the running conversion are unchanged.
- R8: With `idle_i`=1 and `keep_alive_i`=0, `powered_o` falls one clock later. A running conversion is aborted on the following clock, `done_o` stays 0, and starts are ignored until power returns.
- R9: With `keep_alive_i`=1, idle has no effect. `powered_o` stays 1 and conversions complete normally.
- R10: After reset, `busy_o`, `done_o`, `result_o`, `dac_code_o` and `mux_sel_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Conversion request, sampled each clock |
| chan_i | input | 3 | Input channel for the next conversion |
| mode8_i | input | 1 | 1 selects the fast 8-bit mode |
| idle_i | input | 1 | Chip is in idle mode |
| keep_alive_i | input | 1 | 1 keeps the converter powered in idle |
| cmp_i | input | 1 | Comparator: 1 when input is at or above the DAC level |
| mux_sel_o | output | 3 | Analog multiplexer select |
| dac_code_o | output | 10 | Trial code for the external DAC |
| result_o | output | 10 | Last completed result |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | Last conversion completed |
| powered_o | output | 1 | Converter is powered |

## Verification
Several properties are checked on every clock. Busy and done are never high together. The latched channel stays stable while busy. The trial mask has at most one bit set. A power-off while busy clears busy without raising done. Every rising edge of done comes exactly 12 times the mode's cycle count after its start. Only the bench's scenarios can show the numeric results against a modelled comparator, the most-significant-first order of trial codes, the ignored mid-conversion start and the keep-alive behaviour in idle.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the SAR sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package sar_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_TRIAL  = 2'd2
    } sar_phase_e;
endpackage

// File: rtl/sar_tick_div.sv
`timescale 1ns/1ps
// Module: sar_tick_div
// Produces a one-clock machine-cycle tick every DIV clocks while run is high.
// Assumes: the divider restarts from zero whenever run is low, so the first
// tick of a conversion comes exactly DIV clocks after run rises.
module sar_tick_div #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    // Count clocks inside one machine cycle, held at zero when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == LAST);

    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/sar_pwr_ctl.sv
`timescale 1ns/1ps
// Module: sar_pwr_ctl
// Registers the converter power state from the idle and keep-alive inputs.
// Assumes: power is on unless the chip is idle without keep-alive.
module sar_pwr_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic idle_i,
    input  logic keep_alive_i,
    output logic pwr_on
);
    // Track whether the analog part should be powered.
    always_ff @(posedge clk) begin
        if (!rst_n) pwr_on <= 1'b1;
        else pwr_on <= !(idle_i && !keep_alive_i);
    end

    assert_keep_alive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        keep_alive_i |=> pwr_on);
endmodule

// File: rtl/sar_ctrl.sv
`timescale 1ns/1ps
// Module: sar_ctrl
// Conversion state machine: latches channel and mode, waits the sampling
// cycles, then runs one bit trial per tick, most-significant bit first.
// Assumes: cmp is valid on the tick that closes each trial; the fast result
// occupies the upper RES_FAST bits of the RES_FULL-bit result.
module sar_ctrl
    import sar_seq_pkg::*;
#(
    parameter int RES_FULL = 10,
    parameter int RES_FAST = 8,
    parameter int CYC_FULL = 50,
    parameter int CYC_FAST = 24,
    parameter int TICK_DIV = 12,
    parameter int CH_W     = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                pwr_on,
    input  logic                start,
    input  logic [CH_W-1:0]     chan,
    input  logic                mode8,
    input  logic                cmp,
    output logic                busy,
    output logic                done,
    output logic [CH_W-1:0]     ch_q,
    output logic [RES_FULL-1:0] dac_code,
    output logic [RES_FULL-1:0] result
);
    localparam int SAMP_FULL = CYC_FULL - RES_FULL;
    localparam int SAMP_FAST = CYC_FAST - RES_FAST;
    localparam int CW        = $clog2(SAMP_FULL + 1);
    localparam int LOW_FAST  = RES_FULL - RES_FAST;
    localparam logic [RES_FULL-1:0] MSB_MASK = {1'b1, {(RES_FULL-1){1'b0}}};
    localparam logic [CW-1:0] SAMP_FULL_LAST = CW'(SAMP_FULL - 1);
    localparam logic [CW-1:0] SAMP_FAST_LAST = CW'(SAMP_FAST - 1);
    localparam logic [15:0] LEN_FULL = 16'(CYC_FULL * TICK_DIV);
    localparam logic [15:0] LEN_FAST = 16'(CYC_FAST * TICK_DIV);

    sar_phase_e          phase_q;
    logic                mode8_q;
    logic [CW-1:0]       cyc_q;
    logic [RES_FULL-1:0] sar_q;
    logic [RES_FULL-1:0] mask_q;
    logic [RES_FULL-1:0] kept;
    logic [CW-1:0]       samp_last;
    logic                last_bit;
    logic                start_ok;

    // Trial code, comparator decision and end-of-phase markers.
    always_comb begin
        dac_code  = (phase_q == PH_TRIAL) ? (sar_q | mask_q) : '0;
        kept      = cmp ? (sar_q | mask_q) : sar_q;
        last_bit  = mode8_q ? mask_q[LOW_FAST] : mask_q[0];
        samp_last = mode8_q ? SAMP_FAST_LAST : SAMP_FULL_LAST;
        start_ok  = start && pwr_on && (phase_q == PH_IDLE);
    end

    assign busy = (phase_q != PH_IDLE);

    // Conversion sequencing: accept, sample, trial bits, finish or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            mode8_q <= 1'b0;
            ch_q    <= '0;
            cyc_q   <= '0;
            sar_q   <= '0;
            mask_q  <= '0;
            result  <= '0;
            done    <= 1'b0;
        end else if (busy && !pwr_on) begin
            phase_q <= PH_IDLE;
            cyc_q   <= '0;
            sar_q   <= '0;
            mask_q  <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start_ok) begin
                        ch_q    <= chan;
                        mode8_q <= mode8;
                        done    <= 1'b0;
                        cyc_q   <= '0;
                        sar_q   <= '0;
                        phase_q <= PH_SAMPLE;
                    end
                end
                PH_SAMPLE: begin
                    if (tick) begin
                        if (cyc_q == samp_last) begin
                            mask_q  <= MSB_MASK;
                            phase_q <= PH_TRIAL;
                        end else begin
                            cyc_q <= cyc_q + 1'b1;
                        end
                    end
                end
                PH_TRIAL: begin
                    if (tick) begin
                        sar_q  <= kept;
                        mask_q <= mask_q >> 1;
                        if (last_bit) begin
                            result  <= kept;
                            done    <= 1'b1;
                            mask_q  <= '0;
                            phase_q <= PH_IDLE;
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Checker counter: clocks since the accepting edge of the current start.
    logic [15:0] conv_clks_q;
    always_ff @(posedge clk) begin
        if (!rst_n) conv_clks_q <= '0;
        else if (start_ok) conv_clks_q <= '0;
        else if (busy && conv_clks_q != 16'hFFFF) conv_clks_q <= conv_clks_q + 1'b1;
    end

    assert_busy_done_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    assert_chan_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ch_q));
    assert_mask_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mask_q));
    assert_abort_no_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pwr_on) |=> (!busy && !done));
    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && pwr_on) |=> (busy || done));
    assert_conv_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && !mode8_q) |-> (conv_clks_q == LEN_FULL));
    assert_conv_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && mode8_q) |-> (conv_clks_q == LEN_FAST));
endmodule

// File: rtl/sar_adc_seq.sv
`timescale 1ns/1ps
// Module: sar_adc_seq (top)
// Digital sequencer of an 8-input, dual-resolution SAR converter.
// Assumes: the external comparator compares the selected input against the
// DAC level of dac_code_o and settles within one machine cycle.
module sar_adc_seq #(
    parameter int NUM_CH   = 8,
    parameter int RES_FULL = 10,
    parameter int RES_FAST = 8,
    parameter int CYC_FULL = 50,
    parameter int CYC_FAST = 24,
    parameter int TICK_DIV = 12,
    localparam int CH_W    = $clog2(NUM_CH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [CH_W-1:0]     chan_i,
    input  logic                mode8_i,
    input  logic                idle_i,
    input  logic                keep_alive_i,
    input  logic                cmp_i,
    output logic [CH_W-1:0]     mux_sel_o,
    output logic [RES_FULL-1:0] dac_code_o,
    output logic [RES_FULL-1:0] result_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                powered_o
);
    logic pwr_on;
    logic tick;

    sar_pwr_ctl i_pwr (
        .clk          (clk),
        .rst_n        (rst_n),
        .idle_i       (idle_i),
        .keep_alive_i (keep_alive_i),
        .pwr_on       (pwr_on)
    );

    sar_tick_div #(.DIV(TICK_DIV)) i_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy_o),
        .tick  (tick)
    );

    sar_ctrl #(
        .RES_FULL (RES_FULL),
        .RES_FAST (RES_FAST),
        .CYC_FULL (CYC_FULL),
        .CYC_FAST (CYC_FAST),
        .TICK_DIV (TICK_DIV),
        .CH_W     (CH_W)
    ) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .pwr_on   (pwr_on),
        .start    (start_i),
        .chan     (chan_i),
        .mode8    (mode8_i),
        .cmp      (cmp_i),
        .busy     (busy_o),
        .done     (done_o),
        .ch_q     (mux_sel_o),
        .dac_code (dac_code_o),
        .result   (result_o)
    );

    assign powered_o = pwr_on;
endmodule

// File: tb/test_sar_adc_seq.sv
`timescale 1ns/1ps
// Bench: directed scenarios against a behavioural comparator model.
module test_sar_adc_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [2:0] chan_i = '0;
    logic       mode8_i = 1'b0;
    logic       idle_i = 1'b0;
    logic       keep_alive_i = 1'b0;
    logic       cmp_i;
    logic [2:0] mux_sel_o;
    logic [9:0] dac_code_o;
    logic [9:0] result_o;
    logic       busy_o, done_o, powered_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [9:0] vin [8];

    always #2.5 clk = ~clk;

    // Comparator model: 1 when the selected input is at or above the DAC level.
    assign cmp_i = (vin[mux_sel_o] >= dac_code_o);

    sar_adc_seq i_sar_adc_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
        .mode8_i(mode8_i), .idle_i(idle_i), .keep_alive_i(keep_alive_i),
        .cmp_i(cmp_i), .mux_sel_o(mux_sel_o), .dac_code_o(dac_code_o),
        .result_o(result_o), .busy_o(busy_o), .done_o(done_o),
        .powered_o(powered_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Pulse start for one clock; returns just after the accepting edge.
    task automatic do_start(input logic [2:0] ch, input logic m8);
        @(negedge clk);
        chan_i = ch; mode8_i = m8; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!done_o && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset();
        check(busy_o == 0, "R10 busy", busy_o, 0);
        check(done_o == 0, "R10 done", done_o, 0);
        check(result_o == 0, "R10 result", result_o, 0);
        check(dac_code_o == 0, "R10 dac", dac_code_o, 0);
        check(mux_sel_o == 0, "R10 mux", mux_sel_o, 0);
    endtask

    task automatic t_full(input logic [2:0] ch);
        int n;
        do_start(ch, 1'b0);
        check(mux_sel_o == ch, "R1 mux", mux_sel_o, ch);
        check(done_o == 0, "R6 done cleared", done_o, 0);
        wait_done(n);
        check(n == 600, "R3 length", n, 600);
        check(result_o == vin[ch], "R2 result", result_o, vin[ch]);
    endtask

    task automatic t_fast(input logic [2:0] ch);
        int n;
        logic [9:0] exp;
        exp = vin[ch] & 10'h3FC;
        do_start(ch, 1'b1);
        wait_done(n);
        check(n == 288, "R4 length", n, 288);
        check(result_o == exp, "R4 result", result_o, exp);
        check(result_o[1:0] == 0, "R4 low bits", result_o[1:0], 0);
    endtask

    task automatic t_msb_first();
        int n;
        bit zero_ok = 1'b1;
        do_start(3'd2, 1'b0);
        for (int i = 0; i < 479; i++) begin
            @(negedge clk);
            if (dac_code_o != 0) zero_ok = 1'b0;
        end
        check(zero_ok, "R5 dac zero while sampling", zero_ok, 1);
        @(negedge clk);
        check(dac_code_o == 10'h200, "R5 first trial", dac_code_o, 10'h200);
        repeat (12) @(negedge clk);
        check(dac_code_o == 10'h300, "R5 second trial", dac_code_o, 10'h300);
        wait_done(n);
        check(result_o == vin[2], "R2 result ch2", result_o, vin[2]);
    endtask

    task automatic t_ignore_start();
        int n;
        do_start(3'd3, 1'b0);
        repeat (100) @(negedge clk);
        chan_i = 3'd1; mode8_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(mux_sel_o == 3'd3, "R7 channel kept", mux_sel_o, 3);
        wait_done(n);
        check(n + 101 == 600, "R7 end time", n + 101, 600);
        check(result_o == vin[3], "R7 result", result_o, vin[3]);
    endtask

    task automatic t_idle_abort();
        bit done_seen = 1'b0;
        logic [9:0] prev;
        prev = result_o;
        do_start(3'd7, 1'b0);
        repeat (50) @(negedge clk);
        idle_i = 1'b1; keep_alive_i = 1'b0;
        @(negedge clk);
        check(powered_o == 0, "R8 powered off", powered_o, 0);
        @(negedge clk);
        check(busy_o == 0, "R8 aborted", busy_o, 0);
        check(done_o == 0, "R8 no done", done_o, 0);
        do_start(3'd1, 1'b0);
        check(busy_o == 0, "R8 start ignored off", busy_o, 0);
        for (int i = 0; i < 700; i++) begin
            @(negedge clk);
            if (done_o) done_seen = 1'b1;
        end
        check(!done_seen, "R8 done stays low", done_seen, 0);
        check(result_o == prev, "R8 result untouched", result_o, prev);
        idle_i = 1'b0;
        @(negedge clk);
        check(powered_o == 1, "R8 power back", powered_o, 1);
    endtask

    task automatic t_idle_keep();
        int n;
        idle_i = 1'b1; keep_alive_i = 1'b1;
        do_start(3'd1, 1'b0);
        wait_done(n);
        check(powered_o == 1, "R9 powered", powered_o, 1);
        check(n == 600, "R9 length", n, 600);
        check(result_o == vin[1], "R9 result", result_o, vin[1]);
        idle_i = 1'b0; keep_alive_i = 1'b0;
    endtask

    initial begin
        vin[0] = 10'd0;   vin[1] = 10'd1023; vin[2] = 10'h2AA; vin[3] = 10'h155;
        vin[4] = 10'd513; vin[5] = 10'd511;  vin[6] = 10'd7;   vin[7] = 10'd1000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full(3'd2);
        t_full(3'd3);
        t_full(3'd0);
        t_full(3'd7);
        t_fast(3'd4);
        t_fast(3'd5);
        t_fast(3'd6);
        t_msb_first();
        t_ignore_start();
        t_idle_abort();
        t_idle_keep();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule